// File: doc/BRIEF.md
# Endpoint Interrupt Status Register

This block gathers interrupt events from a USB device controller's control endpoint (endpoint 0) and its IN endpoints 1 to 3 into one 32-bit, read-only status word. It watches the handshake flags that each endpoint exposes and detects the transitions that matter. A sticky pending bit is latched for each endpoint, and a single combined interrupt request is raised while any pending bit is set.

Software answers the interrupt request by reading the word at its offset. That read returns the pending bits and clears all of them. Software should read this word before the register that reports USB bus events, because that register must be the last of the interrupt registers read. Each edge is found by comparing a flag with a registered copy of the flag from the previous clock. If a new event arrives in the same cycle as a clearing read, the event is kept.

Top module: `ep_irq_status`

## Requirements
- R1: After a synchronous active-low reset, all pending bits are 0. A read returns 0 and `irq` is low.
- R2: Bits 31:4 of `rd_data` always read 0. `rd_data` is all zeros in any cycle without a hit read. A hit read is `rd_en` high with `rd_addr` equal to 0x08.
- R3: Bit k (k = 1..3) is set when `in_pkt_rdy[k-1]` falls from 1 to 0.
- R4: Bit k (k = 1..3) is set when `in_flush[k-1]` rises from 0 to 1.
- R5: Bit k (k = 1..3) is set when `in_stall_sent[k-1]` rises from 0 to 1.
- R6: Bit 0 is set when any of these occurs: `ctl_out_rdy` rises, `ctl_in_rdy` falls, `ctl_stall_sent` rises, `ctl_setup_end` rises, or `ctl_data_end` falls.
- R7: The opposite transitions set no bit. These are: `in_pkt_rdy` rising, `in_flush` falling, `in_stall_sent` falling, `ctl_out_rdy` falling, `ctl_in_rdy` rising, `ctl_stall_sent` falling, `ctl_setup_end` falling and `ctl_data_end` rising. Flags held at a steady level also set no bit.
- R8: A hit read returns the pending bits in `rd_data[3:0]` in the same cycle, and all pending bits are 0 from the next cycle on.
- R9: A read at any other offset, or address activity with `rd_en` low, leaves the pending bits unchanged.
- R10: When a set event and a hit read fall in the same cycle, the read returns the old bits and the new event's bit is set afterwards.
- R11: `irq` is high exactly when at least one of the pending bits 3:0 is set.
- R12: A pending bit stays set until a hit read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W (8) | Byte offset within the USB block |
| rd_data | output | 32 | Read data; status word on a hit read, zeros otherwise |
| ctl_out_rdy | input | 1 | Endpoint 0 OUT packet-ready flag |
| ctl_in_rdy | input | 1 | Endpoint 0 IN packet-ready flag |
| ctl_stall_sent | input | 1 | Endpoint 0 stall-sent flag |
| ctl_setup_end | input | 1 | Endpoint 0 setup-end flag |
| ctl_data_end | input | 1 | Endpoint 0 data-end flag |
| in_pkt_rdy | input | NUM_IN (3) | IN packet-ready flag, one per IN endpoint (bit 0 = endpoint 1) |
| in_flush | input | NUM_IN (3) | FIFO flush request, one per IN endpoint |
| in_stall_sent | input | NUM_IN (3) | Stall-sent flag, one per IN endpoint |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every flag input is a clean synchronous level, stable between clock edges, and that its value is defined from the first clock edge of reset onward. Under that assumption each registered previous copy agrees with the input's sampled history. The bench holds every flag at 0 while reset is asserted and changes inputs only on falling clock edges. In the random phase each flag toggles with low probability and reads hit other offsets as well as the status word, so events collide with clearing reads and with each other without ever breaking those input rules.

// File: rtl/ep_irq_pkg.sv
// Package ep_irq_pkg
// Shared constants for the endpoint interrupt status register: word width,
// control-endpoint flag ordering inside the edge detector vector.
package ep_irq_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned CTL_FLAGS  = 5;
    // Positions of the control-endpoint flags in the packed flag vector
    localparam int unsigned CTL_OUT    = 0;
    localparam int unsigned CTL_IN     = 1;
    localparam int unsigned CTL_STALL  = 2;
    localparam int unsigned CTL_SETUP  = 3;
    localparam int unsigned CTL_DEND   = 4;
    // Per-IN-endpoint flag ordering inside its group of three
    localparam int unsigned IN_GRP     = 3;
    localparam int unsigned IN_RDY     = 0;
    localparam int unsigned IN_FLUSH   = 1;
    localparam int unsigned IN_STALL   = 2;
endpackage

// File: rtl/ep_irq_edge.sv
// Module ep_irq_edge
// Detects single-cycle rising and falling edges on a vector of level flags by
// comparing each flag with its value at the previous clock edge.
// Assumes: flags are synchronous to clk. The history register samples the
// flags even while reset is asserted, so a flag already high at reset exit
// produces no spurious edge.
module ep_irq_edge #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    // History register: previous-cycle copy of every flag
    always_ff @(posedge clk) begin
        prev_q <= sig;
    end

    // Edge decode against the history copy
    always_comb begin
        rise = sig & ~prev_q;
        fall = prev_q & ~sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        // R3/R5/R6: a transition of the flag is reported as an edge
        p_rise_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sig[i]) |-> rise[i]);
        p_fall_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sig[i]) |-> fall[i]);
        // R7: a steady flag reports no edge
        p_steady_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(sig[i]) |-> !(rise[i] || fall[i]));
    end
endmodule

// File: rtl/ep_irq_pend.sv
// Module ep_irq_pend
// Bank of sticky pending bits. A set request raises its bit; a clear request
// drops every bit not set again in the same cycle, so no event is lost.
// Assumes: set and clr are single-cycle decoded strobes from the same clock.
module ep_irq_pend #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_q;

    // Pending state: clear on read, then merge this cycle's set requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (clr ? '0 : pend_q) | set;
        end
    end

    assign pend = pend_q;

    // R12: without a clear, no pending bit ever drops
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((pend & $past(pend)) == $past(pend)));
    // R8: a clear with no new event empties the bank
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (set == '0)) |=> (pend == '0));
    // R10: an event coinciding with a clear survives it
    p_keep_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/ep_irq_status.sv
// Module ep_irq_status
// Read-only endpoint interrupt status word: bit 0 for the control endpoint,
// bits 1..NUM_IN for the IN endpoints, upper bits reserved as zero. A read
// at REG_OFS returns the word and clears it; irq is the OR of the bits.
// Assumes: rd_en is a one-cycle strobe per read; read data is combinational
// and is zero outside a hit read; there is no write path.
module ep_irq_status
    import ep_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_IN  = 3,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ctl_out_rdy,
    input  logic              ctl_in_rdy,
    input  logic              ctl_stall_sent,
    input  logic              ctl_setup_end,
    input  logic              ctl_data_end,
    input  logic [NUM_IN-1:0] in_pkt_rdy,
    input  logic [NUM_IN-1:0] in_flush,
    input  logic [NUM_IN-1:0] in_stall_sent,
    output logic              irq
);
    localparam int unsigned NBITS  = NUM_IN + 1;
    localparam int unsigned IN_W   = NUM_IN * IN_GRP;
    localparam int unsigned RSVD_W = REG_W - NBITS;

    logic [CTL_FLAGS-1:0] ctl_vec, ctl_rise, ctl_fall;
    logic [IN_W-1:0]      in_vec, in_rise, in_fall;
    logic [NBITS-1:0]     evt;
    logic [NBITS-1:0]     pend;
    logic                 hit;

    // Pack control-endpoint flags in package order
    always_comb begin
        ctl_vec            = '0;
        ctl_vec[CTL_OUT]   = ctl_out_rdy;
        ctl_vec[CTL_IN]    = ctl_in_rdy;
        ctl_vec[CTL_STALL] = ctl_stall_sent;
        ctl_vec[CTL_SETUP] = ctl_setup_end;
        ctl_vec[CTL_DEND]  = ctl_data_end;
    end

    ep_irq_edge #(.W(CTL_FLAGS)) u_ctl_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (ctl_vec),
        .rise (ctl_rise),
        .fall (ctl_fall)
    );

    // Control endpoint: any of the five qualifying transitions
    always_comb begin
        evt[0] = ctl_rise[CTL_OUT] | ctl_fall[CTL_IN] | ctl_rise[CTL_STALL]
               | ctl_rise[CTL_SETUP] | ctl_fall[CTL_DEND];
    end

    for (genvar e = 0; e < NUM_IN; e++) begin : g_in
        // Group each IN endpoint's three flags
        assign in_vec[e*IN_GRP + IN_RDY]   = in_pkt_rdy[e];
        assign in_vec[e*IN_GRP + IN_FLUSH] = in_flush[e];
        assign in_vec[e*IN_GRP + IN_STALL] = in_stall_sent[e];
        // IN endpoint: packet-ready falls, flush starts, or stall is sent
        assign evt[e+1] = in_fall[e*IN_GRP + IN_RDY]
                        | in_rise[e*IN_GRP + IN_FLUSH]
                        | in_rise[e*IN_GRP + IN_STALL];
    end

    ep_irq_edge #(.W(IN_W)) u_in_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (in_vec),
        .rise (in_rise),
        .fall (in_fall)
    );

    // Address decode for the clearing read
    assign hit = rd_en && (rd_addr == REG_OFS);

    ep_irq_pend #(.N(NBITS)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (evt),
        .clr  (hit),
        .pend (pend)
    );

    // Read mux: status word on a hit, zeros otherwise
    always_comb begin
        rd_data = hit ? {{RSVD_W{1'b0}}, pend} : '0;
    end

    // Interrupt request: any pending bit
    assign irq = |pend;

    // R2: reserved bits never drive a one
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:NBITS] == '0);
    // R2: no strobe, no data
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
    // R11: on a read, irq agrees with the returned bits
    p_irq_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (irq == (rd_data[NBITS-1:0] != '0)));
    // R1: the first cycle after reset shows nothing pending
    p_reset_clean_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> !irq);
endmodule

// File: tb/ep_irq_status_tb.sv
// Bench for ep_irq_status: directed corner cases, then seeded random flag
// traffic with reads, all checked against a bench-side model.
module ep_irq_status_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        rd_en = 0;
    logic [7:0]  rd_addr = 0;
    logic [31:0] rd_data;
    logic        c_out = 0, c_in = 0, c_stall = 0, c_setup = 0, c_dend = 0;
    logic [2:0]  i_rdy = 0, i_flush = 0, i_stall = 0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m_pend = 0;
    logic [4:0] m_cprev = 0;
    logic [2:0] m_rprev = 0, m_fprev = 0, m_sprev = 0;

    always #5 clk = ~clk;

    ep_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ctl_out_rdy(c_out), .ctl_in_rdy(c_in),
        .ctl_stall_sent(c_stall), .ctl_setup_end(c_setup),
        .ctl_data_end(c_dend), .in_pkt_rdy(i_rdy), .in_flush(i_flush),
        .in_stall_sent(i_stall), .irq(irq)
    );

    // Expected events from previous and current flag values
    function automatic logic [3:0] exp_evt(input logic [4:0] cp, input logic [4:0] cc,
                                           input logic [2:0] rp, input logic [2:0] rc,
                                           input logic [2:0] fp, input logic [2:0] fc,
                                           input logic [2:0] sp, input logic [2:0] sc);
        logic [3:0] e;
        e[0] = (cc[0] & ~cp[0]) | (cp[1] & ~cc[1]) | (cc[2] & ~cp[2])
             | (cc[3] & ~cp[3]) | (cp[4] & ~cc[4]);
        e[3:1] = (rp & ~rc) | (fc & ~fp) | (sc & ~sp);
        return e;
    endfunction

    function automatic logic exp_hit(input logic en, input logic [7:0] a);
        return en && (a == 8'h08);
    endfunction

    // One cycle: check outputs, then advance the model across the edge
    task automatic step(input string tag);
        logic [31:0] exp_d;
        logic [4:0]  cc;
        #1;
        exp_d = exp_hit(rd_en, rd_addr) ? {28'b0, m_pend} : 32'b0;
        checks++;
        if (rd_data !== exp_d) begin
            fails++;
            $display("FAIL %s rd_data: actual %h expected %h", tag, rd_data, exp_d);
        end
        checks++;
        if (irq !== (m_pend != 0)) begin
            fails++;
            $display("FAIL %s R11 irq: actual %b expected %b", tag, irq, (m_pend != 0));
        end
        @(posedge clk);
        cc = {c_dend, c_setup, c_stall, c_in, c_out};
        m_pend = (exp_hit(rd_en, rd_addr) ? 4'b0 : m_pend)
               | exp_evt(m_cprev, cc, m_rprev, i_rdy, m_fprev, i_flush, m_sprev, i_stall);
        m_cprev = cc; m_rprev = i_rdy; m_fprev = i_flush; m_sprev = i_stall;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        rd_en = 1; rd_addr = a;
        step(tag);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: clean state after reset
        rd("R1", 8'h08);
        // R3 / R7 per IN endpoint
        for (int e = 0; e < 3; e++) begin
            i_rdy[e] = 1; step("R7 rdy rise");
            rd("R7", 8'h08);
            i_rdy[e] = 0; step("R3 rdy fall");
            rd("R3", 8'h08);
            rd("R8 cleared", 8'h08);
        end
        // R4 flush and R5 stall, with their falling edges ignored (R7)
        for (int e = 0; e < 3; e++) begin
            i_flush[e] = 1; step("R4 flush");
            i_flush[e] = 0; rd("R4", 8'h08);
            rd("R7 flush fall", 8'h08);
            i_stall[e] = 1; step("R5 stall");
            i_stall[e] = 0; rd("R5", 8'h08);
            rd("R7 stall fall", 8'h08);
        end
        // R6: each control-endpoint event
        c_out = 1; step("R6 out"); rd("R6 out", 8'h08);
        c_out = 0; rd("R7 out fall", 8'h08);
        c_in = 1; rd("R7 in rise", 8'h08);
        c_in = 0; step("R6 in"); rd("R6 in", 8'h08);
        c_stall = 1; step("R6 stall"); rd("R6 stall", 8'h08);
        c_stall = 0; c_setup = 1; step("R6 setup"); rd("R6 setup", 8'h08);
        c_setup = 0; c_dend = 1; rd("R7 dend rise", 8'h08);
        c_dend = 0; step("R6 dend"); rd("R6 dend", 8'h08);
        // R9 / R12: wrong offset and idle address leave bits set
        i_stall[1] = 1; step("R12 set");
        rd("R9 other offset", 8'h0C);
        rd_addr = 8'h08; step("R9 no strobe");
        step("R12 hold");
        rd("R12", 8'h08);
        // R10: event on the clearing read cycle
        i_stall[1] = 0; i_stall[2] = 1; rd("R10 collide", 8'h08);
        rd("R10 survived", 8'h08);
        i_stall[2] = 0; i_rdy = 3'b111; c_in = 1; step("pre");
        // R11 with all bits pending
        i_rdy = 3'b000; c_in = 0; step("R11 set all");
        rd("R11 all", 8'h08);
        // Random traffic mixing events and reads (R2 R8 R10 R12)
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(7) == 0) c_out   = ~c_out;
            if ($urandom_range(7) == 0) c_in    = ~c_in;
            if ($urandom_range(7) == 0) c_stall = ~c_stall;
            if ($urandom_range(7) == 0) c_setup = ~c_setup;
            if ($urandom_range(7) == 0) c_dend  = ~c_dend;
            for (int e = 0; e < 3; e++) begin
                if ($urandom_range(9) == 0) i_rdy[e]   = ~i_rdy[e];
                if ($urandom_range(9) == 0) i_flush[e] = ~i_flush[e];
                if ($urandom_range(9) == 0) i_stall[e] = ~i_stall[e];
            end
            rd_addr = ($urandom_range(3) == 0) ? 8'($urandom_range(255)) : 8'h08;
            rd_en   = ($urandom_range(5) == 0);
            step("R8 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule